// File: doc/BRIEF.md
# Trigger Pattern Player with Expected-Trigger Scoring

This block turns a trigger board into a stimulus source for testing trigger logic. A host fills a pattern table in which every word holds one pixel pattern plus one flag marking where the unit under test should fire. Once started, the player presents one table word per tick on the pixel outputs. It walks a programmable address range, either once or repeating. Patterns can be simple coincidences across neighbouring pixels, or sequences spread over several words. Spreading a pattern over words lets individual pixels lead or lag one another by whole ticks.

While it plays, the block scores the trigger that comes back from the unit under test against the flagged words. A returned trigger that arrives no more than a programmable number of ticks (0 to 15) after a flagged word is a hit. A flagged word that gets no trigger within that window is a miss. A returned trigger with no open window is spurious. Three saturating counters accumulate these outcomes for the host, and they restart from zero every time playback is launched.

The table defaults to 1K words. Setting the address width to 14 gives 16K words of 38 bits.

Top module: `trig_pattern_player`

## Requirements
- R1: A host write with `tbl_wr_en` high while playback is idle stores `tbl_wr_data` at `tbl_wr_addr`. Bits [PIX_W-1:0] of a word are the pixel pattern. Bit PIX_W is the expected-trigger flag.
- R2: After reset the block is idle, with `running`, `pix_out`, `exp_out` and all counters at zero. A `cmd_start` pulse while idle, with `cmd_stop` low, sets `running` on the next clock edge.
- R3: Each cycle in which `tick` is high while running is one step. On that step's clock edge, `pix_out` and `exp_out` take the word at the current address, and the address then advances by one. Without `tick`, the outputs hold.
- R4: With `cfg_loop` low, the step that plays address `cfg_last` is the final one, and `running` falls on that same edge.
- R5: With `cfg_loop` high, the step after the one that plays `cfg_last` plays `cfg_first` again, and playback continues.
- R6: A `cmd_stop` pulse clears `running` and suppresses any step in that cycle. A `cmd_start` pulse while running is ignored.
- R7: Host writes issued while running leave the table unchanged.
- R8: `dut_trig` is sampled in the cycle after each step. A trigger sampled k steps after a flagged word, with 0 ≤ k ≤ `cfg_latency`, adds one to `cnt_match` and closes that word's window.
- R9: A flagged word whose window of `cfg_latency` steps passes without a trigger adds one to `cnt_miss`. So does a flagged word still waiting when the next flagged word plays without a trigger in that step. In that case the new word opens a fresh window.
- R10: A sampled trigger with no open window, and no flagged word in the same step, adds one to `cnt_spur`.
- R11: Each counter stops at its all-ones value and never wraps.
- R12: Launching playback clears all three counters and any open window on the same edge that sets `running`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tbl_wr_en | input | 1 | Host table write strobe |
| tbl_wr_addr | input | ADDR_W | Host table write address |
| tbl_wr_data | input | PIX_W+1 | Host table word (flag in top bit) |
| cfg_first | input | ADDR_W | First address of the playback range |
| cfg_last | input | ADDR_W | Last address of the playback range |
| cfg_loop | input | 1 | 1 = repeat the range, 0 = play once |
| cfg_latency | input | LAT_W | Scoring window length in steps |
| cmd_start | input | 1 | Launch playback pulse |
| cmd_stop | input | 1 | Halt playback pulse |
| tick | input | 1 | Step strobe |
| dut_trig | input | 1 | Trigger returned by the unit under test |
| running | output | 1 | Playback active |
| pix_out | output | PIX_W | Pixel pattern of the current word |
| exp_out | output | 1 | Expected-trigger flag of the current word |
| cnt_match | output | CNT_W | Hits |
| cnt_miss | output | CNT_W | Misses |
| cnt_spur | output | CNT_W | Spurious triggers |

## Verification
The bench sweeps every window length from 0 to 3 against trigger delays from 0 to 5 steps. A design that is off by one at the window edge would turn a hit at the exact latency into a miss plus a spurious count. The bench also plays a second flagged word on top of a still-open window. A design that drops or double-counts the first word would show the wrong split between hits and misses. Looped playback is interrupted by a tick pause, an ignored relaunch and a write. Playing the written address afterwards shows whether a write leaked into the table while running. A small counter width is driven past its maximum to catch wrap-around, and the next launch must zero all three counters.

// File: rtl/trig_pg_pkg.sv
// Shared types for the trigger pattern player.
// Assumes: one scoring event of each kind at most per step.
package trig_pg_pkg;

    // Outcome pulses produced by the scorer for one step
    typedef struct packed {
        logic spur;
        logic miss;
        logic match;
    } score_t;

    localparam int NUM_SCORE = 3;

endpackage

// File: rtl/pattern_table.sv
// Pattern storage: one write port for the host, one registered read port
// for playback. Assumes the caller gates writes; read data resets to zero.
module pattern_table #(
    parameter int ADDR_W = 10,
    parameter int WORD_W = 38
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];

    // Host write into the array
    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_addr] <= wr_data;
    end

    // Registered read on each playback step; holds otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_en)
            rd_data <= mem[rd_addr];
    end
endmodule

// File: rtl/play_sequencer.sv
// Playback address sequencer: start/stop control, range walk, one-shot or
// loop. Assumes cfg_* stay stable while running. Stop wins over start/step.
module play_sequencer #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic              cmd_stop,
    input  logic              tick,
    input  logic [ADDR_W-1:0] cfg_first,
    input  logic [ADDR_W-1:0] cfg_last,
    input  logic              cfg_loop,
    output logic              running,
    output logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              step_q,
    output logic              launch
);
    // Step and launch qualification
    always_comb begin
        step   = running & tick & ~cmd_stop;
        launch = cmd_start & ~running & ~cmd_stop;
    end

    // Run state, address walk and delayed step strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            addr    <= '0;
            step_q  <= 1'b0;
        end else begin
            step_q <= step;
            if (cmd_stop) begin
                running <= 1'b0;
            end else if (launch) begin
                running <= 1'b1;
                addr    <= cfg_first;
            end else if (step) begin
                if (addr == cfg_last) begin
                    if (cfg_loop)
                        addr <= cfg_first;
                    else
                        running <= 1'b0;
                end else begin
                    addr <= addr + 1'b1;
                end
            end
        end
    end

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && !running && !cmd_stop) |=> running);

    // R4
    oneshot_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && addr == cfg_last && !cfg_loop) |=> !running);

    // R5
    loop_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && addr == cfg_last && cfg_loop) |=> (running && addr == $past(cfg_first)));
endmodule

// File: rtl/trig_matcher.sv
// Scores returned triggers against expected flags, one decision per step.
// Assumes at most one open window; a new flag supersedes an unmatched one.
module trig_matcher
    import trig_pg_pkg::*;
#(
    parameter int LAT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic             exp_bit,
    input  logic             trig,
    input  logic [LAT_W-1:0] lat,
    output score_t           score
);
    logic             pend, pend_n;
    logic [LAT_W-1:0] age, age_n;
    logic             t_left;

    // Resolve the open window first, then the new flag, then leftovers
    always_comb begin
        score  = '0;
        pend_n = pend;
        age_n  = age;
        t_left = trig;
        if (step) begin
            if (pend) begin
                if (trig) begin
                    score.match = 1'b1;
                    t_left      = 1'b0;
                    pend_n      = 1'b0;
                end else if (exp_bit || age >= lat) begin
                    score.miss = 1'b1;
                    pend_n     = 1'b0;
                end else begin
                    age_n = age + 1'b1;
                end
            end
            if (exp_bit) begin
                if (t_left) begin
                    score.match = 1'b1;
                    t_left      = 1'b0;
                end else if (lat == '0) begin
                    score.miss = 1'b1;
                end else begin
                    pend_n = 1'b1;
                    age_n  = LAT_W'(1);
                end
            end
            if (t_left)
                score.spur = 1'b1;
        end
    end

    // Window state register
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            pend <= 1'b0;
            age  <= '0;
        end else begin
            pend <= pend_n;
            age  <= age_n;
        end
    end

    // R9
    window_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && step && pend && !trig && !exp_bit && age >= lat) |=> !pend);
endmodule

// File: rtl/sat_counter.sv
// Saturating event counter with synchronous clear. Clear has priority.
module sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] TOP = '1;

    // Count up until all-ones
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt <= '0;
        else if (inc && cnt != TOP)
            cnt <= cnt + 1'b1;
    end

    // R11
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && cnt == TOP) |=> cnt == TOP);

    // R11
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> cnt >= $past(cnt));
endmodule

// File: rtl/trig_pattern_player.sv
// Trigger pattern player: plays table words onto pixel outputs per tick and
// scores the returned trigger. Assumes cfg_* stable during playback.
module trig_pattern_player
    import trig_pg_pkg::*;
#(
    parameter int PIX_W  = 37,
    parameter int ADDR_W = 10,
    parameter int CNT_W  = 16,
    parameter int LAT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tbl_wr_en,
    input  logic [ADDR_W-1:0] tbl_wr_addr,
    input  logic [PIX_W:0]    tbl_wr_data,
    input  logic [ADDR_W-1:0] cfg_first,
    input  logic [ADDR_W-1:0] cfg_last,
    input  logic              cfg_loop,
    input  logic [LAT_W-1:0]  cfg_latency,
    input  logic              cmd_start,
    input  logic              cmd_stop,
    input  logic              tick,
    input  logic              dut_trig,
    output logic              running,
    output logic [PIX_W-1:0]  pix_out,
    output logic              exp_out,
    output logic [CNT_W-1:0]  cnt_match,
    output logic [CNT_W-1:0]  cnt_miss,
    output logic [CNT_W-1:0]  cnt_spur
);
    localparam int WORD_W = PIX_W + 1;

    logic              step, step_q, launch, wr_ok;
    logic [ADDR_W-1:0] rd_addr;
    logic [WORD_W-1:0] rd_word;
    score_t            score;
    logic [NUM_SCORE-1:0] inc_vec;
    logic [CNT_W-1:0]  cnt_arr [NUM_SCORE];

    // Host writes only while idle
    always_comb wr_ok = tbl_wr_en & ~running;

    play_sequencer #(.ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
        .tick(tick), .cfg_first(cfg_first), .cfg_last(cfg_last),
        .cfg_loop(cfg_loop), .running(running), .step(step), .addr(rd_addr),
        .step_q(step_q), .launch(launch)
    );

    pattern_table #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_tbl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_ok), .wr_addr(tbl_wr_addr),
        .wr_data(tbl_wr_data), .rd_en(step), .rd_addr(rd_addr),
        .rd_data(rd_word)
    );

    // Split the presented word into pattern and flag
    always_comb begin
        pix_out = rd_word[PIX_W-1:0];
        exp_out = rd_word[PIX_W];
    end

    trig_matcher #(.LAT_W(LAT_W)) u_match (
        .clk(clk), .rst_n(rst_n), .clear(launch), .step(step_q),
        .exp_bit(rd_word[PIX_W]), .trig(dut_trig), .lat(cfg_latency),
        .score(score)
    );

    // Pack scorer pulses in counter order: match, miss, spur
    always_comb inc_vec = {score.spur, score.miss, score.match};

    for (genvar g = 0; g < NUM_SCORE; g++) begin : g_cnt
        sat_counter #(.W(CNT_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .clr(launch), .inc(inc_vec[g]),
            .cnt(cnt_arr[g])
        );
    end

    // Counter outputs
    always_comb begin
        cnt_match = cnt_arr[0];
        cnt_miss  = cnt_arr[1];
        cnt_spur  = cnt_arr[2];
    end

    // R12
    launch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> (cnt_match == '0 && cnt_miss == '0 && cnt_spur == '0));
endmodule

// File: tb/test_trig_pattern_player.sv
`timescale 1ns/1ps
module test_trig_pattern_player;
    localparam int PIX_W = 37, ADDR_W = 4, CNT_W = 8, LAT_W = 4;

    logic clk = 0, rst_n = 0;
    logic tbl_wr_en = 0;
    logic [ADDR_W-1:0] tbl_wr_addr = '0, cfg_first = '0, cfg_last = '0;
    logic [PIX_W:0] tbl_wr_data = '0;
    logic cfg_loop = 0, cmd_start = 0, cmd_stop = 0, tick = 0, dut_trig = 0;
    logic [LAT_W-1:0] cfg_latency = '0;
    logic running, exp_out;
    logic [PIX_W-1:0] pix_out;
    logic [CNT_W-1:0] cnt_match, cnt_miss, cnt_spur;

    trig_pattern_player #(.PIX_W(PIX_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LAT_W(LAT_W)) i_trig_pattern_player (
        .clk(clk), .rst_n(rst_n), .tbl_wr_en(tbl_wr_en), .tbl_wr_addr(tbl_wr_addr),
        .tbl_wr_data(tbl_wr_data), .cfg_first(cfg_first), .cfg_last(cfg_last),
        .cfg_loop(cfg_loop), .cfg_latency(cfg_latency), .cmd_start(cmd_start),
        .cmd_stop(cmd_stop), .tick(tick), .dut_trig(dut_trig), .running(running),
        .pix_out(pix_out), .exp_out(exp_out), .cnt_match(cnt_match),
        .cnt_miss(cnt_miss), .cnt_spur(cnt_spur)
    );

    always #4 clk = ~clk;

    int total = 0, bad = 0;
    logic [PIX_W:0] tbl [16];
    logic [PIX_W:0] shown = '0;
    logic [ADDR_W-1:0] m_addr = '0;
    logic m_run = 0;

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [PIX_W:0] word_of(int a, logic f, int salt);
        logic [PIX_W-1:0] p;
        p = PIX_W'(a * 32'h9E37_79B1) ^ PIX_W'(salt) ^ (PIX_W'(a) << 32);
        return {f, p};
    endfunction

    task automatic host_wr(int a, logic [PIX_W:0] w, logic mirror);
        @(negedge clk);
        tbl_wr_en = 1; tbl_wr_addr = ADDR_W'(a); tbl_wr_data = w;
        @(negedge clk);
        tbl_wr_en = 0;
        if (mirror) tbl[a] = w;
    endtask

    task automatic launch();
        @(negedge clk); cmd_start = 1;
        @(negedge clk); cmd_start = 0;
        m_run = 1; m_addr = cfg_first;
    endtask

    task automatic halt();
        @(negedge clk); cmd_stop = 1;
        @(negedge clk); cmd_stop = 0;
        m_run = 0;
    endtask

    // Tick every cycle; dut_trig for step i is driven in the cycle after it
    task automatic run_steps(int n, logic [63:0] tv, logic all_trig);
        for (int i = 0; i <= n; i++) begin
            @(negedge clk);
            if (i > 0) begin
                chk("R3 pix", 64'(pix_out), 64'(shown[PIX_W-1:0]));
                chk("R3 flag", 64'(exp_out), 64'(shown[PIX_W]));
            end
            tick = (i < n);
            dut_trig = (i > 0) ? (all_trig | tv[i-1]) : 1'b0;
            if (i < n && m_run) begin
                shown = tbl[m_addr];
                if (m_addr == cfg_last) begin
                    if (cfg_loop) m_addr = cfg_first; else m_run = 0;
                end else m_addr = m_addr + 1'b1;
            end
        end
        @(negedge clk); tick = 0; dut_trig = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R2 reset state
        chk("R2 running", 64'(running), 0);
        chk("R2 pix", 64'(pix_out), 0);
        chk("R2 counters", 64'({cnt_match, cnt_miss, cnt_spur}), 0);
        rst_n = 1;

        // R1 load table; flag only at word 2
        for (int a = 0; a < 16; a++) host_wr(a, word_of(a, a == 2, 0), 1);

        // R8 R9 R10 sweep window length vs trigger delay (R4 one-shot end)
        for (int L = 0; L < 4; L++) begin
            for (int d = 0; d < 6; d++) begin
                cfg_first = 0; cfg_last = 7; cfg_loop = 0; cfg_latency = LAT_W'(L);
                launch();
                chk("R2 started", 64'(running), 1);
                run_steps(8, 64'(1) << (2 + d), 0);
                chk("R4 stopped after last", 64'(running), 0);
                chk("R8 match", 64'(cnt_match), (d <= L) ? 1 : 0);
                chk("R9 miss", 64'(cnt_miss), (d <= L) ? 0 : 1);
                chk("R10 spur", 64'(cnt_spur), (d <= L) ? 0 : 1);
            end
        end

        // R9 supersede: flags at 2 and 4, L=3, triggers at steps 0 and 5
        host_wr(4, word_of(4, 1, 0), 1);
        cfg_latency = 3;
        launch();
        run_steps(8, 64'b10_0001, 0);
        chk("R8 match after supersede", 64'(cnt_match), 1);
        chk("R9 superseded miss", 64'(cnt_miss), 1);
        chk("R10 early trigger spur", 64'(cnt_spur), 1);

        // R5 loop over 3..5, R6 ignored relaunch, R7 write while running
        cfg_first = 3; cfg_last = 5; cfg_loop = 1;
        launch();
        run_steps(7, 0, 0);
        chk("R5 still running", 64'(running), 1);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R3 hold without tick", 64'(pix_out), 64'(shown[PIX_W-1:0]));
        end
        @(negedge clk); cfg_first = 9; cmd_start = 1;
        @(negedge clk); cmd_start = 0; cfg_first = 3;
        host_wr(4, word_of(4, 0, 32'h5A5A), 0);
        run_steps(3, 0, 0);
        chk("R6 relaunch ignored", 64'(running), 1);
        halt();
        chk("R6 stop", 64'(running), 0);
        run_steps(2, 0, 0);
        cfg_first = 4; cfg_last = 4; cfg_loop = 0;
        launch();
        run_steps(1, 0, 0);
        chk("R7 write while running dropped", 64'(pix_out), 64'(tbl[4][PIX_W-1:0]));

        // R11 saturation on spurious counter, then R12 clear on launch
        host_wr(0, word_of(0, 0, 7), 1);
        host_wr(1, word_of(1, 0, 7), 1);
        cfg_first = 0; cfg_last = 1; cfg_loop = 1;
        launch();
        run_steps(300, 0, 1);
        halt();
        chk("R11 spur saturates", 64'(cnt_spur), 255);
        chk("R11 match untouched", 64'(cnt_match), 0);
        launch();
        chk("R12 counters cleared", 64'({cnt_match, cnt_miss, cnt_spur}), 0);
        halt();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule